// File: doc/BRIEF.md
# Pseudonoise Backlight Level Modulator

The block turns a programmed backlight intensity into a one-bit light output. Software writes an 8-bit level and an enable bit over a small 32-bit register bus. While the functional clock is present and the enable bit is set, the block produces a pulse stream. In that stream the fraction of high cycles equals level/256.

The high cycles are not grouped into one pulse per period. A free-running pseudonoise generator advances once per functional-clock cycle. The output is high whenever the generator value is below the effective intensity. The generator is an 8-bit maximal-length shift register extended with an all-zero state, so it walks through all 256 values in every 256-cycle window. The generator keeps its state while the functional clock is absent.

The effective intensity is exported as a status value. A one-cycle change strobe marks every change of that value. Only full-word accesses to the two defined registers are serviced. Narrow accesses and accesses to unmapped offsets raise error flags and leave the state untouched.

Top module: `pnbl_top`

## Requirements
- R1: After reset the stored level is 0, the enable bit is 0, `eff_level` is 0, `light_out` is low, `eff_chg` is low, and the clock-present flag is taken as set.
- R2: A word write (`bus_size`=2) to offset 0x000 stores `bus_wdata[7:0]` as the level. A word read (`bus_req`=1, `bus_we`=0) of 0x000 returns the level zero-extended to 32 bits. Read data is 0 whenever no read is requested.
- R3: A word write to offset 0x004 stores only `bus_wdata[0]` as the enable bit. A word read of 0x004 returns the enable bit in bit 0 with all other bits zero.
- R4: `eff_level` equals the stored level when both the enable bit and the clock-present flag are set, and 0 otherwise. The clock-present flag is `fclk_on` registered at each clock edge. `eff_level` therefore follows a register write, or a change of `fclk_on`, one clock edge later.
- R5: While `fclk_on` is high and `eff_level` is constant at N, `light_out` is high in exactly N cycles of any 256 consecutive cycles. This also holds right after a period with `fclk_on` low.
- R6: While `eff_level` is 0, `light_out` stays low. This covers the cases where the block is disabled or the functional clock is absent.
- R7: An access with `bus_size` other than 2 (0 = byte, 1 = halfword, 3 = reserved) raises `err_width` in the access cycle. Such a read returns 0, and such a write changes neither register.
- R8: A word access to any offset in the 0x800-byte window other than 0x000 or 0x004 raises `err_reg` in the access cycle. Such a read returns 0, and such a write changes neither register. `err_reg` is never raised together with `err_width`.
- R9: `eff_chg` is high for exactly the cycles in which `eff_level` differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| fclk_on | input | 1 | Functional clock present; enables generator advance |
| bus_req | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_addr | input | 11 | Byte offset inside the 0x800-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational in the access cycle |
| err_width | output | 1 | Access rejected for its size |
| err_reg | output | 1 | Word access to an unmapped offset |
| eff_level | output | 8 | Intensity currently in effect |
| eff_chg | output | 1 | One-cycle strobe on each change of `eff_level` |
| light_out | output | 1 | Dithered light output |

## Verification
Each level from 0 to 255 is checked by counting high cycles of `light_out` over a 256-cycle window. If the generator skipped or repeated a state, the count for some levels would be off by one. A stuck or all-zero generator would show as a wrong count within the first window after the level is set. A wrong comparison direction or a wrong gating term shows as a wrong count, or as a nonzero count while disabled, within one window. Errors in register storage or decode show at the next read-back or in `eff_level` one cycle after the write. A strobe tied to the wrong register shows at the first level change.

// File: rtl/pnbl_pkg.sv
package pnbl_pkg;

    localparam int ADDR_W = 11;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_LEVEL = 11'h000;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 11'h004;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_LEVEL,
        SEL_CTRL,
        SEL_BAD
    } reg_sel_e;

    typedef struct packed {
        logic              req;
        logic              we;
        acc_size_e         size;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // Feedback mask for a shift-left Fibonacci register of the given width.
    function automatic logic [15:0] lfsr_taps(input int w);
        case (w)
            4:       return 16'h000C;
            5:       return 16'h0014;
            6:       return 16'h0030;
            7:       return 16'h0060;
            default: return 16'h00B8;
        endcase
    endfunction

endpackage

// File: rtl/pnbl_regs.sv
module pnbl_regs
    import pnbl_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          bq,
    output logic [DATA_W-1:0] rdata,
    output logic              err_width,
    output logic              err_reg,
    output logic [LVL_W-1:0]  level_q,
    output logic              en_q
);

    localparam int PAD_W = DATA_W - LVL_W;

    reg_sel_e sel;
    logic     word_ok;
    logic     unused_wdata_hi;

    assign unused_wdata_hi = ^bq.wdata[DATA_W-1:LVL_W];
    assign word_ok = (bq.size == SZ_WORD);

    always_comb begin
        sel = SEL_NONE;
        if (bq.req && word_ok) begin
            if (bq.addr == OFF_LEVEL)     sel = SEL_LEVEL;
            else if (bq.addr == OFF_CTRL) sel = SEL_CTRL;
            else                          sel = SEL_BAD;
        end
    end

    assign err_width = bq.req && !word_ok;
    assign err_reg   = (sel == SEL_BAD);

    always_comb begin
        rdata = '0;
        if (!bq.we) begin
            case (sel)
                SEL_LEVEL: rdata = {{PAD_W{1'b0}}, level_q};
                SEL_CTRL:  rdata = {{(DATA_W-1){1'b0}}, en_q};
                default:   rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            en_q    <= 1'b0;
        end else if (bq.we) begin
            if (sel == SEL_LEVEL) level_q <= bq.wdata[LVL_W-1:0];
            if (sel == SEL_CTRL)  en_q    <= bq.wdata[0];
        end
    end

endmodule

// File: rtl/pnbl_lfsr.sv
module pnbl_lfsr
    import pnbl_pkg::*;
#(
    parameter int          W           = 8,
    parameter logic [W-1:0] SEED       = 1,
    parameter bit          FULL_PERIOD = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] state
);

    localparam logic [15:0]  TAPS_ALL = lfsr_taps(W);
    localparam logic [W-1:0] TAPS     = TAPS_ALL[W-1:0];

    logic lin_fb;
    logic fb;

    assign lin_fb = ^(state & TAPS);

    generate
        if (FULL_PERIOD) begin : g_full
            // Splice the all-zero state in after the lone-top-bit state.
            assign fb = lin_fb ^ (state[W-2:0] == '0);
        end else begin : g_plain
            assign fb = lin_fb;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)      state <= SEED;
        else if (adv) state <= {state[W-2:0], fb};
    end

endmodule

// File: rtl/pnbl_mod.sv
module pnbl_mod #(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fclk_on,
    input  logic [LVL_W-1:0] level,
    input  logic             en,
    input  logic [LVL_W-1:0] pn,
    output logic [LVL_W-1:0] eff,
    output logic             chg,
    output logic             light
);

    logic             clk_seen_q;
    logic [LVL_W-1:0] eff_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_seen_q <= 1'b1;
            eff_prev_q <= '0;
        end else begin
            clk_seen_q <= fclk_on;
            eff_prev_q <= eff;
        end
    end

    assign eff   = (clk_seen_q && en) ? level : '0;
    assign chg   = (eff != eff_prev_q);
    assign light = (pn < eff);

endmodule

// File: rtl/pnbl_top.sv
module pnbl_top
    import pnbl_pkg::*;
#(
    parameter int          LVL_W = 8,
    parameter logic [7:0]  SEED  = 8'h5A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fclk_on,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [1:0]        bus_size,
    input  logic [10:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              err_width,
    output logic              err_reg,
    output logic [LVL_W-1:0]  eff_level,
    output logic              eff_chg,
    output logic              light_out
);

    bus_req_t         bq;
    logic [LVL_W-1:0] level_q;
    logic             en_q;
    logic [LVL_W-1:0] pn_state;

    assign bq.req   = bus_req;
    assign bq.we    = bus_we;
    assign bq.size  = acc_size_e'(bus_size);
    assign bq.addr  = bus_addr;
    assign bq.wdata = bus_wdata;

    pnbl_regs #(.LVL_W(LVL_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bq        (bq),
        .rdata     (bus_rdata),
        .err_width (err_width),
        .err_reg   (err_reg),
        .level_q   (level_q),
        .en_q      (en_q)
    );

    pnbl_lfsr #(
        .W           (LVL_W),
        .SEED        (SEED[LVL_W-1:0]),
        .FULL_PERIOD (1'b1)
    ) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .adv   (fclk_on),
        .state (pn_state)
    );

    pnbl_mod #(.LVL_W(LVL_W)) u_mod (
        .clk     (clk),
        .rst     (rst),
        .fclk_on (fclk_on),
        .level   (level_q),
        .en      (en_q),
        .pn      (pn_state),
        .eff     (eff_level),
        .chg     (eff_chg),
        .light   (light_out)
    );

endmodule

// File: rtl/pnbl_chk.sv
module pnbl_chk #(
    parameter int LVL_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_req,
    input logic             bus_we,
    input logic [1:0]       bus_size,
    input logic [10:0]      bus_addr,
    input logic [31:0]      bus_rdata,
    input logic             err_width,
    input logic             err_reg,
    input logic [LVL_W-1:0] eff_level,
    input logic             eff_chg,
    input logic             light_out
);

    logic mapped;
    assign mapped = (bus_addr == 11'h000) || (bus_addr == 11'h004);

    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (eff_level == '0) && !light_out);

    assert_ctrl_read_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && bus_size == 2'd2 && bus_addr == 11'h004)
        |-> (bus_rdata[31:1] == '0));

    assert_dark_when_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (eff_level == '0) |-> !light_out);

    assert_narrow_reject_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_size != 2'd2) |-> (err_width && !err_reg && bus_rdata == '0));

    assert_unmapped_reject_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_size == 2'd2 && !mapped) |-> (err_reg && !err_width && bus_rdata == '0));

    assert_no_err_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !bus_req |-> (!err_reg && !err_width));

    assert_strobe_on_change_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(eff_level) |-> eff_chg);

    assert_strobe_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        $stable(eff_level) |-> !eff_chg);

endmodule

bind pnbl_top pnbl_chk #(.LVL_W(LVL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .err_width (err_width),
    .err_reg   (err_reg),
    .eff_level (eff_level),
    .eff_chg   (eff_chg),
    .light_out (light_out)
);

// File: tb/pnbl_top_tb.sv
`timescale 1ns/1ps
module pnbl_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fclk_on = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_size = 2'd2;
    logic [10:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        err_width;
    logic        err_reg;
    logic [7:0]  eff_level;
    logic        eff_chg;
    logic        light_out;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pnbl_top u_dut (
        .clk(clk), .rst(rst), .fclk_on(fclk_on),
        .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .err_width(err_width), .err_reg(err_reg), .eff_level(eff_level),
        .eff_chg(eff_chg), .light_out(light_out)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One bus access; results sampled in the access cycle. Returns at negedge+1 after the edge.
    task automatic acc(input logic we, input logic [1:0] sz, input logic [10:0] a,
                       input logic [31:0] d, output logic [31:0] rd,
                       output logic ew, output logic er);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = d;
        #1;
        rd = bus_rdata; ew = err_width; er = err_reg;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; bus_size = 2'd2; bus_addr = '0; bus_wdata = '0;
        #1;
    endtask

    task automatic count_window(output int n);
        n = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk); #1;
            n += int'(light_out);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic ew, er;
        int n;
        int exp_lvl;

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1: reset state
        check(eff_level == 0, "R1 eff_level", eff_level, 0);
        check(!light_out, "R1 light_out", light_out, 0);
        check(!eff_chg, "R1 eff_chg", eff_chg, 0);
        acc(0, 2'd2, 11'h000, 0, rd, ew, er);
        check(rd == 0, "R1 level read", rd, 0);
        acc(0, 2'd2, 11'h004, 0, rd, ew, er);
        check(rd == 0, "R1 ctrl read", rd, 0);
        check(bus_rdata == 0, "R2 idle rdata", bus_rdata, 0);

        // R2: level store, upper bits dropped
        acc(1, 2'd2, 11'h000, 32'hFFFF_FFA5, rd, ew, er);
        acc(0, 2'd2, 11'h000, 0, rd, ew, er);
        check(rd == 32'hA5, "R2 level readback", rd, 32'hA5);
        check(!ew && !er, "R2 no error", {ew, er}, 0);
        check(eff_level == 0, "R4 disabled eff", eff_level, 0);

        // R3: control stores only bit 0
        acc(1, 2'd2, 11'h004, 32'hFFFF_FFFE, rd, ew, er);
        acc(0, 2'd2, 11'h004, 0, rd, ew, er);
        check(rd == 0, "R3 ctrl bit0 clear", rd, 0);
        acc(1, 2'd2, 11'h004, 32'h0000_0003, rd, ew, er);
        // R9: strobe in the cycle after the enabling write edge; R4 one edge later
        check(eff_chg, "R9 strobe on enable", eff_chg, 1);
        check(eff_level == 8'hA5, "R4 eff follows level", eff_level, 8'hA5);
        @(negedge clk); #1;
        check(!eff_chg, "R9 strobe one cycle", eff_chg, 0);
        acc(0, 2'd2, 11'h004, 0, rd, ew, er);
        check(rd == 1, "R3 ctrl readback", rd, 1);

        // R9: rewriting the same level gives no strobe
        acc(1, 2'd2, 11'h000, 32'hA5, rd, ew, er);
        check(!eff_chg, "R9 no strobe on same value", eff_chg, 0);

        // R7: narrow and reserved sizes rejected
        for (int sz = 0; sz < 4; sz++) begin
            if (sz == 2) continue;
            acc(1, 2'(sz), 11'h000, 32'h11, rd, ew, er);
            check(ew && !er, "R7 narrow write flag", {ew, er}, 2);
            check(eff_level == 8'hA5, "R7 narrow write ignored", eff_level, 8'hA5);
            acc(1, 2'(sz), 11'h004, 32'h0, rd, ew, er);
            check(eff_level == 8'hA5, "R7 narrow ctrl write ignored", eff_level, 8'hA5);
            acc(0, 2'(sz), 11'h000, 0, rd, ew, er);
            check(rd == 0 && ew, "R7 narrow read zero", rd, 0);
        end

        // R8: unmapped word offsets
        for (int k = 0; k < 6; k++) begin
            logic [10:0] a;
            a = (k == 0) ? 11'h008 : (k == 1) ? 11'h7FC : (k == 2) ? 11'h001 :
                (k == 3) ? 11'h010 : (k == 4) ? 11'h400 : 11'h005;
            acc(1, 2'd2, a, 32'h0, rd, ew, er);
            check(er && !ew, "R8 bad reg write flag", {ew, er}, 1);
            check(eff_level == 8'hA5, "R8 bad reg write ignored", eff_level, 8'hA5);
            acc(0, 2'd2, a, 0, rd, ew, er);
            check(rd == 0 && er, "R8 bad reg read zero", rd, 0);
        end

        // R4/R6: functional clock absent
        @(negedge clk); fclk_on = 1'b0;
        @(negedge clk); #1;
        check(eff_level == 0, "R4 clock off eff", eff_level, 0);
        check(eff_chg, "R9 strobe on clock loss", eff_chg, 1);
        count_window(n);
        check(n == 0, "R6 dark with clock off", n, 0);
        @(negedge clk); fclk_on = 1'b1;
        @(negedge clk); #1;
        check(eff_level == 8'hA5, "R4 clock back eff", eff_level, 8'hA5);
        count_window(n);
        check(n == 8'hA5, "R5 count after clock gap", n, 8'hA5);

        // R6: disabled
        acc(1, 2'd2, 11'h004, 32'h0, rd, ew, er);
        count_window(n);
        check(n == 0, "R6 dark when disabled", n, 0);
        acc(1, 2'd2, 11'h004, 32'h1, rd, ew, er);

        // R5: sweep every level
        for (int lv = 0; lv < 256; lv++) begin
            acc(1, 2'd2, 11'h000, 32'(lv), rd, ew, er);
            exp_lvl = lv;
            check(eff_level == 8'(lv), "R4 eff sweep", eff_level, lv);
            count_window(n);
            check(n == exp_lvl, "R5 duty count", n, exp_lvl);
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule